// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block copies a programmed number of data units from one address range to another over a simple synchronous memory bus. Each unit is read from the source address and then written to the destination address. After each unit, both addresses advance by the unit size. A unit is either one byte or one 16-bit halfword.

Software sets up the source address, the destination address, the unit count and a control word through a small register port. The control word selects the unit width and the trigger kind. Its self-clearing start bit launches the sequence:

- In software mode, the whole count runs back to back.
- In the two hardware modes, the engine waits armed. It moves exactly one unit on each rising edge of the chosen external or internal interrupt line.

When the count runs out, the engine raises a sticky done flag and pulses its interrupt output for one cycle. A zero count completes at once. A 16-bit request with an odd address is refused with an error flag.

Top module: `dma_mover`

## Requirements
- R1: Register offsets on `cfg_addr`: 0 is the source address, 1 is the destination address, 2 is the remaining count, 3 is control and 4 is status. All read back on `cfg_rdata`. The count keeps only its low 10 bits, so the largest count is 1023. All registers, `dma_irq` and `mem_req` are zero after reset.
- R2: Writing control with bit 0 set and trigger kind 0 (bits 3:2) runs every unit back to back. Each unit is one read cycle followed by one write cycle, so a count of N completes in 2N cycles after the accepting edge. Control bit 0 always reads 0.
- R3: Control bit 1 selects 16-bit units, and both addresses then step by 2 per unit. When bit 1 is clear, units are bytes, the addresses step by 1, and only the low data byte is written.
- R4: A start with bit 1 set and an odd source or destination address sets status bit 2 (error). It causes no bus access and leaves the engine idle.
- R5: A start with a count of 0 sets done and pulses `dma_irq` in the accepting edge. It causes no bus access.
- R6: On completion, status bit 1 (done) sets, status bit 0 (busy) clears, and `dma_irq` is high for exactly one cycle. A new start clears done and error.
- R7: Trigger kind 1 arms on the external line numbered by control bits 10:8. Trigger kind 2 or 3 arms on the internal line numbered by bits 20:16. While armed, each rising edge of that line moves one unit. Busy stays set while armed.
- R8: Edges on unselected lines have no effect. A selected edge that arrives while a unit is in progress is dropped. A line already high at arming time is not an edge.
- R9: Writes to offsets 0 to 3 while busy are ignored. Writing 1 to status bit 1 or bit 2 clears done or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| ext_irq | input | N_EXT | External trigger lines |
| int_irq | input | N_INT | Internal trigger lines |
| mem_req | output | 1 | Bus access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_wide | output | 1 | Access is 16 bits |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| dma_irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume a memory that answers every read in the following cycle without stalling. The bench model in the testbench does exactly that.

The assertions also assume that trigger lines and register writes change only between clock edges. The bench drives them on the falling edge.

The even-address assertion relies on the engine itself refusing odd 16-bit starts. The bench therefore provokes that case only through the start path and never forces an odd address mid-sequence.

// File: rtl/dma_mover.sv
module dma_mover #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 10,
  parameter int N_EXT  = 8,
  parameter int N_INT  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [N_EXT-1:0]  ext_irq,
  input  logic [N_INT-1:0]  int_irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              dma_irq
);
  localparam int ESW = (N_EXT > 1) ? $clog2(N_EXT) : 1;
  localparam int ISW = (N_INT > 1) ? $clog2(N_INT) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_READ, S_WRITE} st_t;

  st_t              st;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wide_q, done_q, err_q, irq_q, trig_prev;
  logic [1:0]        mode_q;
  logic [ESW-1:0]    esel_q;
  logic [ISW-1:0]    isel_q;

  logic busy, wr_ok, ctrl_wr, start_req, odd, cur_line, new_line, trig_edge, unused_ok;
  logic [ADDR_W-1:0] step;

  assign busy      = (st != S_IDLE);
  assign wr_ok     = cfg_wr && !busy;
  assign ctrl_wr   = wr_ok && (cfg_addr == 3'd3);
  assign start_req = ctrl_wr && cfg_wdata[0];
  assign odd       = cfg_wdata[1] && (src_q[0] || dst_q[0]);
  assign step      = wide_q ? ADDR_W'(2) : ADDR_W'(1);
  assign cur_line  = mode_q[1] ? int_irq[isel_q] : (mode_q[0] && ext_irq[esel_q]);
  assign new_line  = cfg_wdata[3] ? int_irq[cfg_wdata[16 +: ISW]]
                                  : (cfg_wdata[2] && ext_irq[cfg_wdata[8 +: ESW]]);
  assign trig_edge = cur_line && !trig_prev;
  assign unused_ok = ^cfg_wdata;

  assign mem_req   = (st == S_READ) || (st == S_WRITE);
  assign mem_we    = (st == S_WRITE);
  assign mem_wide  = wide_q;
  assign mem_addr  = (st == S_WRITE) ? dst_q : src_q;
  assign mem_wdata = wide_q ? mem_rdata : {8'h00, mem_rdata[7:0]};
  assign dma_irq   = irq_q;

  always_comb begin
    case (cfg_addr)
      3'd0:    cfg_rdata = 32'(src_q);
      3'd1:    cfg_rdata = 32'(dst_q);
      3'd2:    cfg_rdata = 32'(cnt_q);
      3'd3:    cfg_rdata = (32'(isel_q) << 16) | (32'(esel_q) << 8) | {28'd0, mode_q, wide_q, 1'b0};
      3'd4:    cfg_rdata = {29'd0, err_q, done_q, busy};
      default: cfg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      src_q <= '0; dst_q <= '0; cnt_q <= '0;
      wide_q <= 1'b0; mode_q <= '0; esel_q <= '0; isel_q <= '0;
      done_q <= 1'b0; err_q <= 1'b0; irq_q <= 1'b0; trig_prev <= 1'b0;
    end else begin
      irq_q     <= 1'b0;
      trig_prev <= ctrl_wr ? new_line : cur_line;
      if (wr_ok && cfg_addr == 3'd0) src_q <= cfg_wdata[ADDR_W-1:0];
      if (wr_ok && cfg_addr == 3'd1) dst_q <= cfg_wdata[ADDR_W-1:0];
      if (wr_ok && cfg_addr == 3'd2) cnt_q <= cfg_wdata[CNT_W-1:0];
      if (ctrl_wr) begin
        wide_q <= cfg_wdata[1];
        mode_q <= cfg_wdata[3:2];
        esel_q <= cfg_wdata[8 +: ESW];
        isel_q <= cfg_wdata[16 +: ISW];
      end
      if (cfg_wr && cfg_addr == 3'd4) begin
        if (cfg_wdata[1]) done_q <= 1'b0;
        if (cfg_wdata[2]) err_q  <= 1'b0;
      end
      case (st)
        S_IDLE: if (start_req) begin
          done_q <= 1'b0;
          err_q  <= 1'b0;
          if (odd) err_q <= 1'b1;
          else if (cnt_q == '0) begin
            done_q <= 1'b1;
            irq_q  <= 1'b1;
          end else st <= (cfg_wdata[3:2] == 2'd0) ? S_READ : S_ARMED;
        end
        S_ARMED: if (trig_edge) st <= S_READ;
        S_READ:  st <= S_WRITE;
        S_WRITE: begin
          src_q <= src_q + step;
          dst_q <= dst_q + step;
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            irq_q  <= 1'b1;
          end else st <= (mode_q == 2'd0) ? S_READ : S_ARMED;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_write_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_req && !mem_we));
  assert_count_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  assert_even_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_wide) |-> !mem_addr[0]);
  assert_irq_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_irq |-> (done_q && !busy));
  assert_busy_holds_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(src_q) || $past(mem_we)));
endmodule

// File: tb/dma_mover_bench.sv
module dma_mover_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [7:0] ext_irq = '0;
  logic [31:0] int_irq = '0;
  logic mem_req, mem_we, mem_wide, dma_irq;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] rdata = '0;
  logic [7:0] mem [256];
  int reqs = 0, checks = 0, errors = 0;

  always #2 clk = ~clk;

  dma_mover u_dma_mover (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ext_irq(ext_irq),
    .int_irq(int_irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(rdata), .dma_irq(dma_irq));

  always @(posedge clk) begin
    if (mem_req) reqs <= reqs + 1;
    if (mem_req && !mem_we)
      rdata <= mem_wide ? {mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]} : {8'h00, mem[mem_addr[7:0]]};
    if (mem_req && mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (mem_wide) mem[mem_addr[7:0] + 8'd1] <= mem_wdata[15:8];
    end
  end

  // {wide, count[9:0], dst[7:0], src[7:0]}
  localparam logic [26:0] VEC [4] = '{
    {1'b0, 10'd5,  8'h80, 8'h10},
    {1'b1, 10'd4,  8'hA0, 8'h20},
    {1'b0, 10'd1,  8'hC0, 8'h00},
    {1'b1, 10'd16, 8'hD0, 8'h40}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic fill();
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int r0;
    fill();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d); chk("R1 reset register", d, 32'd0);
    end
    chk("R1 reset irq/req", {31'd0, dma_irq | mem_req}, 32'd0);
    wr(2, 32'hFFFF); rd(2, d); chk("R1 count capped to 10 bits", d, 32'h3FF);

    for (int v = 0; v < 4; v++) begin
      logic [7:0] s, t; logic [9:0] n; logic w; int bytes, bad;
      s = VEC[v][7:0]; t = VEC[v][15:8]; n = VEC[v][25:16]; w = VEC[v][26];
      bytes = int'(n) * (w ? 2 : 1);
      fill();
      wr(0, 32'(s)); wr(1, 32'(t)); wr(2, 32'(n));
      r0 = reqs;
      wr(3, {30'd0, w, 1'b1});
      rd(3, d); chk("R2 start bit self-clears", d & 32'h1, 32'd0);
      repeat (2 * int'(n) - 1) @(negedge clk);
      rd(4, d); chk("R2 still busy before last write", d, 32'd1);
      @(negedge clk);
      rd(4, d); chk("R6 done set busy clear", d, 32'd2);
      chk("R6 irq pulse high", {31'd0, dma_irq}, 32'd1);
      chk("R2 back-to-back bus accesses", 32'(reqs - r0), 32'(2 * int'(n)));
      rd(0, d); chk("R3 source advance", d, 32'(s) + 32'(bytes));
      rd(1, d); chk("R3 destination advance", d, 32'(t) + 32'(bytes));
      rd(2, d); chk("R2 count exhausted", d, 32'd0);
      bad = 0;
      for (int i = 0; i < bytes; i++)
        if (mem[8'(t + 8'(i))] !== (8'(s + 8'(i)) ^ 8'h5A)) bad++;
      chk("R3 data copied", 32'(bad), 32'd0);
      @(negedge clk);
      chk("R6 irq lasts one cycle", {31'd0, dma_irq}, 32'd0);
    end

    // R5 zero count
    wr(2, 0); r0 = reqs; wr(3, 32'h1);
    rd(4, d); chk("R5 zero count done at once", d, 32'd2);
    chk("R5 zero count irq", {31'd0, dma_irq}, 32'd1);
    @(negedge clk); @(negedge clk);
    chk("R5 zero count no bus access", 32'(reqs - r0), 32'd0);

    // R4 odd address with 16-bit units
    wr(0, 32'h11); wr(1, 32'h40); wr(2, 2); r0 = reqs; wr(3, 32'h3);
    rd(4, d); chk("R4 odd wide start refused", d, 32'd4);
    @(negedge clk); @(negedge clk);
    chk("R4 no bus access", 32'(reqs - r0), 32'd0);
    wr(4, 32'h4); rd(4, d); chk("R9 error cleared by write-one", d, 32'd0);

    // R9 writes ignored while busy
    fill();
    wr(0, 32'h00); wr(1, 32'h80); wr(2, 8); wr(3, 32'h1);
    wr(0, 32'hFF); wr(2, 32'h55); wr(3, 32'h3);
    repeat (20) @(negedge clk);
    rd(0, d); chk("R9 source write ignored while busy", d, 32'h08);
    rd(2, d); chk("R9 count write ignored while busy", d, 32'd0);
    rd(3, d); chk("R9 control write ignored while busy", d, 32'd0);
    wr(4, 32'h2); rd(4, d); chk("R9 done cleared by write-one", d, 32'd0);

    // R7/R8 external trigger, line 5
    fill();
    ext_irq[5] = 1'b1;
    wr(0, 32'h60); wr(1, 32'h70); wr(2, 3); r0 = reqs;
    wr(3, (32'd5 << 8) | 32'h5);
    rd(4, d); chk("R7 armed is busy", d, 32'd1);
    repeat (3) @(negedge clk);
    rd(2, d); chk("R8 high line at arming is no edge", d, 32'd3);
    ext_irq[5] = 1'b0;
    ext_irq[2] = 1'b1; repeat (3) @(negedge clk); ext_irq[2] = 1'b0;
    rd(2, d); chk("R8 unselected line ignored", d, 32'd3);
    chk("R8 no bus access while armed", 32'(reqs - r0), 32'd0);
    ext_irq[5] = 1'b1; repeat (3) @(negedge clk);
    rd(2, d); chk("R7 one unit per edge", d, 32'd2);
    ext_irq[5] = 1'b0; @(negedge clk);
    ext_irq[5] = 1'b1; @(negedge clk);
    ext_irq[5] = 1'b0; @(negedge clk);
    ext_irq[5] = 1'b1; repeat (3) @(negedge clk);
    rd(2, d); chk("R8 edge during unit dropped", d, 32'd1);
    ext_irq[5] = 1'b0; @(negedge clk);
    ext_irq[5] = 1'b1; repeat (3) @(negedge clk);
    rd(4, d); chk("R7 external run done", d, 32'd2);
    chk("R7 external irq", {31'd0, dma_irq}, 32'd1);
    chk("R7 external data", {24'd0, mem[8'h72]}, {24'd0, 8'h62 ^ 8'h5A});
    ext_irq[5] = 1'b0;

    // R7 internal trigger, line 17, 16-bit unit
    fill();
    wr(0, 32'h30); wr(1, 32'h90); wr(2, 1);
    wr(3, (32'd17 << 16) | 32'hB);
    int_irq[3] = 1'b1; repeat (3) @(negedge clk); int_irq[3] = 1'b0;
    rd(2, d); chk("R8 unselected internal ignored", d, 32'd1);
    int_irq[17] = 1'b1; repeat (3) @(negedge clk); int_irq[17] = 1'b0;
    rd(4, d); chk("R7 internal run done", d, 32'd2);
    chk("R7 internal 16-bit data", {16'd0, mem[8'h91], mem[8'h90]},
        {16'd0, 8'h31 ^ 8'h5A, 8'h30 ^ 8'h5A});
    rd(0, d); chk("R3 wide step by 2", d, 32'h32);

    finish_run();
  end
endmodule